// File: doc/BRIEF.md
# LCD Palette and Frame Fetch Sequencer

This block drives the memory side of an LCD controller. When the raster is enabled it reads the colour palette from memory, then the frame data, or only one of the two, as the load mode selects. Each region is read as a series of burst requests on a valid/ready request channel. The read words come back on a valid/ready response channel. They pass straight to a pixel-FIFO stream, and a flag on that stream marks palette words. Frame data can come from one buffer or alternate between two buffers. Each buffer is given as an inclusive base/ceiling pair of word addresses.

A status register holds sticky event bits: end of frame for each buffer, palette done, FIFO underflow and sync lost. Software clears a bit by writing a mask with a one in that bit. When an event and a clear land in the same cycle, the event wins. Back-pressure rules:
- A pending request keeps its address and length until it is granted.
- Only one burst is outstanding at a time.
- The response channel is ready only while the burst is in flight and the pixel stream is ready.

Top module: `lcd_fetch_seq`

## Requirements
- R1: After reset the status is zero and neither `req_valid` nor `out_valid` is asserted.
- R2: In load mode 00 the block reads the palette from `base0`, flagging those words with `out_is_pal`=1. It then reads frame data from `base0` through `ceil0` with `out_is_pal`=0.
- R3: In load mode 01 the block reads only the palette and then issues no further requests. While the raster stays enabled it keeps raising palette done (status bit 6), so a clear written in that time has no effect.
- R4: In load mode 10 (and 11) no palette is read, and the first request starts at `base0`.
- R5: `burst_code` values 0..4 mean bursts of 1, 2, 4, 8 and 16 words, and larger values mean 16. The last burst of a region is shortened so that no word past the ceiling is requested.
- R6: With `dual_buf_en`=1, each completed frame switches the next fetch to the other buffer's base/ceiling pair. With `dual_buf_en`=0, every frame restarts at `base0`.
- R7: Completing the region of buffer 0 sets status bit 8, and completing buffer 1 sets bit 9. Both are set only when `eof_irq_en`=1.
- R8: Completing the palette sets status bit 6, only when `pal_irq_en`=1.
- R9: A cycle with `stat_clr_en`=1 clears every status bit whose `stat_clr_mask` bit is 1, unless the same bit is set by an event in that cycle.
- R10: `pix_demand` and `fifo_empty` both high while the raster is enabled set underflow (bit 5). A further underflow while bit 5 is still set also sets sync lost (bit 2). With the raster disabled, underflow is ignored.
- R11: `req_valid` holds `req_addr` and `req_len` until `req_ready`, and every granted word is delivered on the output stream under back-pressure.
- R12: The palette is 8 words (32 bytes) when `pal_large`=0 and 128 words (512 bytes) when `pal_large`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raster_en | input | 1 | Raster enable; a rising level starts the sequence |
| load_mode | input | 2 | 00 palette+data, 01 palette only, 10/11 data only |
| dual_buf_en | input | 1 | Alternate between buffer 0 and buffer 1 |
| burst_code | input | 3 | Burst size code (1 << code words, capped at 16) |
| pal_large | input | 1 | Palette size select (8-bit pixel mode) |
| pal_irq_en | input | 1 | Enable for the palette-done event |
| eof_irq_en | input | 1 | Enable for the end-of-frame events |
| base0 | input | AW | Buffer 0 first word address, also the palette base |
| ceil0 | input | AW | Buffer 0 last word address (inclusive) |
| base1 | input | AW | Buffer 1 first word address |
| ceil1 | input | AW | Buffer 1 last word address (inclusive) |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request grant |
| req_addr | output | AW | Burst start word address |
| req_len | output | LW | Burst length in words |
| rsp_valid | input | 1 | Read data valid |
| rsp_ready | output | 1 | Read data accepted |
| rsp_data | input | DW | Read data word |
| out_valid | output | 1 | Pixel-FIFO stream valid |
| out_ready | input | 1 | Pixel-FIFO stream ready |
| out_data | output | DW | Word toward the pixel FIFO |
| out_is_pal | output | 1 | Word belongs to the palette |
| pix_demand | input | 1 | Timing side wants a pixel |
| fifo_empty | input | 1 | Pixel FIFO is empty |
| stat_clr_en | input | 1 | Status clear strobe |
| stat_clr_mask | input | 10 | Write-one-to-clear mask |
| status | output | 10 | Sticky event bits 9, 8, 6, 5, 2 |

## Verification
The sequencer is driven in each load mode.
- The palette-then-data run shows the handover from palette to data, and shows that a data region ending mid-burst gets a shortened burst.
- The palette-only run with the large palette shows that fetching stops and that palette done keeps reasserting.
- Two data-only runs, one dual-buffer and one single-buffer with one-word bursts, tell buffer alternation apart from restart and enabled from gated end-of-frame events.
- A run with grant stalls and stream back-pressure checks that requests stay stable and that no granted word is lost.
- Underflow pulses with the raster on and off separate the first underflow, sync lost and the gated case.

// File: rtl/lcd_fetch_pkg.sv
package lcd_fetch_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_REQ, SEQ_DATA, SEQ_HOLD} seq_state_e;

  localparam int ST_W    = 10;
  localparam int ST_EOF1 = 9;
  localparam int ST_EOF0 = 8;
  localparam int ST_PAL  = 6;
  localparam int ST_UNF  = 5;
  localparam int ST_SYNC = 2;

  localparam logic [1:0] MODE_PAL_ONLY = 2'b01;
endpackage

// File: rtl/lcd_fetch_burst_calc.sv
module lcd_fetch_burst_calc #(
  parameter int AW     = 16,
  parameter int MAXLOG = 4,
  parameter int LW     = MAXLOG + 1
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] ceil,
  input  logic [2:0]    code,
  output logic [LW-1:0] len,
  output logic          last
);
  localparam logic [2:0] CODE_CAP = 3'(MAXLOG);

  logic [AW:0]   remain;
  logic [AW:0]   bw_ext;
  logic [2:0]    code_c;
  logic [LW-1:0] bwords;

  always_comb begin
    remain = {1'b0, ceil} - {1'b0, addr} + (AW+1)'(1);
    code_c = (code > CODE_CAP) ? CODE_CAP : code;
    bwords = LW'(1) << code_c;
    bw_ext = (AW+1)'(bwords);
    last   = (remain <= bw_ext);
    len    = (remain < bw_ext) ? remain[LW-1:0] : bwords;
  end
endmodule

// File: rtl/lcd_fetch_fsm.sv
module lcd_fetch_fsm
  import lcd_fetch_pkg::*;
#(
  parameter int AW        = 16,
  parameter int MAXLOG    = 4,
  parameter int LW        = MAXLOG + 1,
  parameter int PAL_SMALL = 8,
  parameter int PAL_LARGE = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raster_en,
  input  logic [1:0]    load_mode,
  input  logic          dual_en,
  input  logic          pal_large,
  input  logic [2:0]    burst_code,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] ceil0,
  input  logic [AW-1:0] base1,
  input  logic [AW-1:0] ceil1,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [LW-1:0] req_len,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic          out_ready,
  output logic          data_phase,
  output logic          is_pal,
  output logic          ev_pal,
  output logic          ev_eof0,
  output logic          ev_eof1
);
  localparam logic [AW-1:0] PAL_SMALL_LAST = AW'(PAL_SMALL - 1);
  localparam logic [AW-1:0] PAL_LARGE_LAST = AW'(PAL_LARGE - 1);

  seq_state_e    state_q;
  logic          is_pal_q, buf_q, last_q;
  logic [AW-1:0] addr_q, ceil_q;
  logic [LW-1:0] left_q;
  logic [LW-1:0] calc_len;
  logic          calc_last;
  logic          beat, burst_end, region_end;
  logic          nxt_buf;
  logic [AW-1:0] nxt_base, nxt_ceil;

  lcd_fetch_burst_calc #(.AW(AW), .MAXLOG(MAXLOG), .LW(LW)) calc_i (
    .addr(addr_q), .ceil(ceil_q), .code(burst_code),
    .len(calc_len), .last(calc_last)
  );

  always_comb begin
    req_valid  = (state_q == SEQ_REQ);
    req_addr   = addr_q;
    req_len    = calc_len;
    data_phase = (state_q == SEQ_DATA);
    rsp_ready  = data_phase && out_ready;
    is_pal     = is_pal_q;
    beat       = rsp_valid && rsp_ready;
    burst_end  = beat && (left_q == LW'(1));
    region_end = burst_end && last_q;
    nxt_buf    = is_pal_q ? 1'b0 : (dual_en ? ~buf_q : 1'b0);
    nxt_base   = nxt_buf ? base1 : base0;
    nxt_ceil   = nxt_buf ? ceil1 : ceil0;
    ev_pal     = (region_end && is_pal_q) || (state_q == SEQ_HOLD && raster_en);
    ev_eof0    = region_end && !is_pal_q && !buf_q;
    ev_eof1    = region_end && !is_pal_q && buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      is_pal_q <= 1'b0;
      buf_q    <= 1'b0;
      last_q   <= 1'b0;
      addr_q   <= '0;
      ceil_q   <= '0;
      left_q   <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: if (raster_en) begin
          state_q <= SEQ_REQ;
          buf_q   <= 1'b0;
          addr_q  <= base0;
          if (load_mode[1]) begin
            is_pal_q <= 1'b0;
            ceil_q   <= ceil0;
          end else begin
            is_pal_q <= 1'b1;
            ceil_q   <= base0 + (pal_large ? PAL_LARGE_LAST : PAL_SMALL_LAST);
          end
        end
        SEQ_REQ: if (req_ready) begin
          addr_q  <= addr_q + AW'(calc_len);
          left_q  <= calc_len;
          last_q  <= calc_last;
          state_q <= SEQ_DATA;
        end
        SEQ_DATA: if (beat) begin
          left_q <= left_q - LW'(1);
          if (burst_end) begin
            state_q <= raster_en ? SEQ_REQ : SEQ_IDLE;
            if (last_q) begin
              if (is_pal_q && load_mode == MODE_PAL_ONLY) begin
                state_q <= SEQ_HOLD;
              end else begin
                is_pal_q <= 1'b0;
                buf_q    <= nxt_buf;
                addr_q   <= nxt_base;
                ceil_q   <= nxt_ceil;
              end
            end
          end
        end
        SEQ_HOLD: if (!raster_en) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len));

  assert_no_overread_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ({1'b0, req_addr} + (AW+1)'(req_len) - (AW+1)'(1)) <= {1'b0, ceil_q});

  assert_len_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= (LW'(1) << MAXLOG)));

  assert_hold_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == SEQ_HOLD |=> !req_valid);
endmodule

// File: rtl/lcd_fetch_status.sv
module lcd_fetch_status
  import lcd_fetch_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_pal,
  input  logic            ev_eof0,
  input  logic            ev_eof1,
  input  logic            pal_irq_en,
  input  logic            eof_irq_en,
  input  logic            raster_en,
  input  logic            pix_demand,
  input  logic            fifo_empty,
  input  logic            clr_en,
  input  logic [ST_W-1:0] clr_mask,
  output logic [ST_W-1:0] status
);
  logic [ST_W-1:0] status_q, set_vec, clr_vec;
  logic            unf;

  always_comb begin
    unf              = raster_en && pix_demand && fifo_empty;
    set_vec          = '0;
    set_vec[ST_EOF1] = ev_eof1 && eof_irq_en;
    set_vec[ST_EOF0] = ev_eof0 && eof_irq_en;
    set_vec[ST_PAL]  = ev_pal && pal_irq_en;
    set_vec[ST_UNF]  = unf;
    set_vec[ST_SYNC] = unf && status_q[ST_UNF];
    clr_vec          = clr_en ? clr_mask : '0;
    status           = status_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  assert_w1c_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en && clr_mask[ST_EOF0] && !set_vec[ST_EOF0] |=> !status_q[ST_EOF0]);

  assert_sync_needs_unf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[ST_SYNC]) |-> status_q[ST_UNF]);

  assert_pal_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[ST_PAL]) |-> $past(pal_irq_en));

  assert_eof_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status_q[ST_EOF1]) |-> $past(eof_irq_en));
endmodule

// File: rtl/lcd_fetch_seq.sv
module lcd_fetch_seq
  import lcd_fetch_pkg::*;
#(
  parameter int AW              = 16,
  parameter int DW              = 32,
  parameter int MAXLOG          = 4,
  parameter int WORD_BYTES      = 4,
  parameter int PAL_SMALL_BYTES = 32,
  parameter int PAL_LARGE_BYTES = 512,
  parameter int LW              = MAXLOG + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          raster_en,
  input  logic [1:0]    load_mode,
  input  logic          dual_buf_en,
  input  logic [2:0]    burst_code,
  input  logic          pal_large,
  input  logic          pal_irq_en,
  input  logic          eof_irq_en,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] ceil0,
  input  logic [AW-1:0] base1,
  input  logic [AW-1:0] ceil1,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [LW-1:0] req_len,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_is_pal,
  input  logic          pix_demand,
  input  logic          fifo_empty,
  input  logic          stat_clr_en,
  input  logic [9:0]    stat_clr_mask,
  output logic [9:0]    status
);
  localparam int PAL_SMALL = PAL_SMALL_BYTES / WORD_BYTES;
  localparam int PAL_LARGE = PAL_LARGE_BYTES / WORD_BYTES;

  logic data_phase, ev_pal, ev_eof0, ev_eof1;

  lcd_fetch_fsm #(
    .AW(AW), .MAXLOG(MAXLOG), .LW(LW),
    .PAL_SMALL(PAL_SMALL), .PAL_LARGE(PAL_LARGE)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .load_mode(load_mode),
    .dual_en(dual_buf_en), .pal_large(pal_large), .burst_code(burst_code),
    .base0(base0), .ceil0(ceil0), .base1(base1), .ceil1(ceil1),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .out_ready(out_ready), .data_phase(data_phase), .is_pal(out_is_pal),
    .ev_pal(ev_pal), .ev_eof0(ev_eof0), .ev_eof1(ev_eof1)
  );

  lcd_fetch_status status_i (
    .clk(clk), .rst_n(rst_n), .ev_pal(ev_pal), .ev_eof0(ev_eof0),
    .ev_eof1(ev_eof1), .pal_irq_en(pal_irq_en), .eof_irq_en(eof_irq_en),
    .raster_en(raster_en), .pix_demand(pix_demand), .fifo_empty(fifo_empty),
    .clr_en(stat_clr_en), .clr_mask(stat_clr_mask), .status(status)
  );

  assign out_valid = rsp_valid && data_phase;
  assign out_data  = rsp_data;
endmodule

// File: tb/lcd_fetch_seq_tb_top.sv
module lcd_fetch_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        raster_en = 1'b0;
  logic [1:0]  load_mode = 2'b00;
  logic        dual_buf_en = 1'b0;
  logic [2:0]  burst_code = 3'd0;
  logic        pal_large = 1'b0;
  logic        pal_irq_en = 1'b0;
  logic        eof_irq_en = 1'b0;
  logic [15:0] base0 = '0, ceil0 = '0, base1 = '0, ceil1 = '0;
  logic        req_valid, req_ready = 1'b1;
  logic [15:0] req_addr;
  logic [4:0]  req_len;
  logic        rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_data = '0;
  logic        out_valid, out_ready = 1'b1, out_is_pal;
  logic [31:0] out_data;
  logic        pix_demand = 1'b0, fifo_empty = 1'b0;
  logic        stat_clr_en = 1'b0;
  logic [9:0]  stat_clr_mask = '0;
  logic [9:0]  status;

  always #5 clk = ~clk;

  lcd_fetch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .raster_en(raster_en), .load_mode(load_mode),
    .dual_buf_en(dual_buf_en), .burst_code(burst_code), .pal_large(pal_large),
    .pal_irq_en(pal_irq_en), .eof_irq_en(eof_irq_en),
    .base0(base0), .ceil0(ceil0), .base1(base1), .ceil1(ceil1),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_is_pal(out_is_pal), .pix_demand(pix_demand),
    .fifo_empty(fifo_empty), .stat_clr_en(stat_clr_en),
    .stat_clr_mask(stat_clr_mask), .status(status)
  );

  int checks = 0, fails = 0, cyc = 0;
  int log_n = 0, pal_beats = 0, data_beats = 0, len_sum = 0;
  logic [15:0] log_addr [0:63];
  int          log_len  [0:63];
  bit stall_en = 0, bp_en = 0;
  bit req_fire_q = 0, beat_fire_q = 0, prev_pend = 0;
  logic [15:0] req_addr_q = '0, prev_addr = '0, mem_addr = '0;
  int req_len_q = 0, mem_left = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory and monitors, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (beat_fire_q) begin
      mem_addr = mem_addr + 16'd1;
      mem_left = mem_left - 1;
    end
    if (req_fire_q) begin
      mem_addr = req_addr_q;
      mem_left = req_len_q;
    end
    rsp_valid = (mem_left > 0);
    rsp_data  = {16'hC0DE, mem_addr};
    req_ready = stall_en ? ((cyc % 4) == 3) : 1'b1;
    out_ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
    #1;
    if (prev_pend)
      chk(req_valid && req_addr == prev_addr, "R11 request held", {req_valid, req_addr}, {1'b1, prev_addr});
    prev_pend   = req_valid && !req_ready;
    prev_addr   = req_addr;
    req_fire_q  = req_valid && req_ready;
    req_addr_q  = req_addr;
    req_len_q   = int'(req_len);
    beat_fire_q = rsp_valid && rsp_ready;
    if (req_fire_q) begin
      if (log_n < 64) begin
        log_addr[log_n] = req_addr;
        log_len[log_n]  = int'(req_len);
      end
      log_n++;
      len_sum += int'(req_len);
    end
    if (out_valid && out_ready) begin
      if (out_is_pal) pal_beats++;
      else data_beats++;
    end
  end

  task automatic wait_log(input int n);
    for (int i = 0; i < 3000 && log_n < n; i++) @(negedge clk);
  endtask

  task automatic go_idle();
    @(negedge clk);
    raster_en = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic clear_log();
    log_n = 0; pal_beats = 0; data_beats = 0; len_sum = 0;
  endtask

  task automatic clr_status(input logic [9:0] m);
    @(negedge clk);
    stat_clr_en = 1'b1; stat_clr_mask = m;
    @(negedge clk);
    stat_clr_en = 1'b0; stat_clr_mask = '0;
    @(negedge clk);
  endtask

  task automatic chk_req(input int i, input logic [15:0] a, input int l, input string tag);
    chk(log_addr[i] == a && log_len[i] == l, tag, {log_addr[i], 8'(log_len[i])}, {a, 8'(l)});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(status == 10'd0, "R1 status", status, 0);
    chk(!req_valid && !out_valid, "R1 idle outputs", {req_valid, out_valid}, 0);
  endtask

  task automatic t_pal_data();
    clear_log();
    load_mode = 2'b00; pal_large = 1'b0; burst_code = 3'd2; dual_buf_en = 1'b0;
    base0 = 16'h0100; ceil0 = 16'h0111; pal_irq_en = 1'b1; eof_irq_en = 1'b1;
    raster_en = 1'b1;
    wait_log(8);
    go_idle();
    chk_req(0, 16'h0100, 4, "R2 palette first burst");
    chk_req(1, 16'h0104, 4, "R2 palette second burst");
    chk_req(2, 16'h0100, 4, "R2 data starts at base0");
    chk_req(5, 16'h010C, 4, "R5 burst of 4");
    chk_req(6, 16'h0110, 2, "R5 shortened last burst");
    chk_req(7, 16'h0100, 4, "R2 frame repeats");
    chk(pal_beats == 8, "R12 small palette words", pal_beats, 8);
    chk(data_beats == len_sum - 8, "R2 data words delivered", data_beats, len_sum - 8);
    chk(status[6] && status[8] && !status[9], "R7 R8 events", status, 10'h140);
    clr_status(10'h100);
    chk(!status[8] && status[6], "R9 masked clear", status, 10'h040);
    clr_status(10'h3FF);
    chk(status == 10'd0, "R9 full clear", status, 0);
  endtask

  task automatic t_pal_only();
    clear_log();
    load_mode = 2'b01; pal_large = 1'b1; burst_code = 3'd4;
    base0 = 16'h0200; pal_irq_en = 1'b1; eof_irq_en = 1'b1;
    @(negedge clk); raster_en = 1'b1;
    repeat (400) @(negedge clk);
    chk(log_n == 8, "R3 palette only request count", log_n, 8);
    chk_req(7, 16'h0270, 16, "R12 large palette last burst");
    chk(pal_beats == 128 && data_beats == 0, "R3 no data words", {pal_beats, data_beats}, 128);
    clr_status(10'h3FF);
    chk(status[6] && !status[8], "R3 palette done reasserts", status, 10'h040);
    go_idle();
    clr_status(10'h3FF);
    chk(status == 10'd0, "R9 clear after raster off", status, 0);
  endtask

  task automatic t_dual();
    clear_log();
    load_mode = 2'b10; dual_buf_en = 1'b1; burst_code = 3'd3;
    base0 = 16'h0300; ceil0 = 16'h0305; base1 = 16'h0400; ceil1 = 16'h0402;
    eof_irq_en = 1'b1; pal_irq_en = 1'b1;
    @(negedge clk); raster_en = 1'b1;
    wait_log(4);
    go_idle();
    chk_req(0, 16'h0300, 6, "R4 data only from base0");
    chk_req(1, 16'h0400, 3, "R6 switch to buffer 1");
    chk_req(2, 16'h0300, 6, "R6 back to buffer 0");
    chk_req(3, 16'h0400, 3, "R6 buffer 1 again");
    chk(pal_beats == 0, "R4 no palette words", pal_beats, 0);
    chk(status == 10'h300, "R7 both end-of-frame bits", status, 10'h300);
    clr_status(10'h3FF);
  endtask

  task automatic t_single();
    clear_log();
    load_mode = 2'b11; dual_buf_en = 1'b0; burst_code = 3'd0;
    base0 = 16'h0300; ceil0 = 16'h0301; base1 = 16'h0500; ceil1 = 16'h0507;
    eof_irq_en = 1'b0;
    @(negedge clk); raster_en = 1'b1;
    wait_log(4);
    go_idle();
    chk_req(0, 16'h0300, 1, "R5 burst code 0");
    chk_req(1, 16'h0301, 1, "R5 single word bursts");
    chk_req(2, 16'h0300, 1, "R6 single buffer restart");
    chk(status == 10'd0, "R7 gated end-of-frame", status, 0);
  endtask

  task automatic t_underflow();
    clear_log();
    load_mode = 2'b10; base0 = 16'h0300; ceil0 = 16'h0307; burst_code = 3'd2;
    @(negedge clk); raster_en = 1'b1;
    pix_demand = 1'b1; fifo_empty = 1'b1;
    @(negedge clk); pix_demand = 1'b0;
    @(negedge clk);
    chk(status[5] && !status[2], "R10 first underflow", status, 10'h020);
    pix_demand = 1'b1;
    @(negedge clk); pix_demand = 1'b0;
    @(negedge clk);
    chk(status[5] && status[2], "R10 sync lost", status, 10'h024);
    go_idle();
    clr_status(10'h3FF);
    pix_demand = 1'b1;
    @(negedge clk); pix_demand = 1'b0; fifo_empty = 1'b0;
    @(negedge clk);
    chk(status == 10'd0, "R10 ignored with raster off", status, 0);
  endtask

  task automatic t_backpressure();
    clear_log();
    load_mode = 2'b10; dual_buf_en = 1'b0; burst_code = 3'd2;
    base0 = 16'h0300; ceil0 = 16'h030B; eof_irq_en = 1'b0;
    stall_en = 1; bp_en = 1;
    @(negedge clk); raster_en = 1'b1;
    wait_log(6);
    go_idle();
    stall_en = 0; bp_en = 0;
    chk_req(2, 16'h0308, 4, "R11 stalled burst order");
    chk_req(3, 16'h0300, 4, "R11 restart under stalls");
    chk(data_beats == len_sum, "R11 every granted word delivered", data_beats, len_sum);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pal_data();
    t_pal_only();
    t_dual();
    t_single();
    t_underflow();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule